// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and turns them into two processor requests: a fast request for sources typed as fast, and a normal request that is vectored. Each source has an enable bit and a type bit. Enable bits are set and cleared through two separate write-one registers. A software register can raise any source by hand. Every source also owns a programmable handler address.

Software services a normal interrupt in two steps. A read of the vector register returns the handler address of the winning source and marks that source as in service. A later write of any value to the same register ends service of that source. Lower index means higher priority. A source in service hides itself and every lower-priority source from the normal request until it is ended. A higher-priority source can still interrupt it, which gives nested service. Fast sources bypass vectoring entirely.

The register port takes one access per cycle. Writes take effect at the clock edge of the access. Read data is registered and appears after that same edge.

Top module: `vic_ctrl`

## Requirements
- R1: After synchronous reset, enables, types, soft bits, the in-service set, the default vector and every per-source vector are zero, and both `irq_o` and `fiq_o` are low.
- R2: A write to ENSET (word 0x04) sets each enable bit whose data bit is 1 and leaves the others unchanged. The enables read back at ENABLE (word 0x03).
- R3: A write to ENCLR (word 0x05) clears each enable bit whose data bit is 1. Data bits at 0 have no effect.
- R4: TYPE (word 0x06, read/write) selects normal routing with 0 and fast routing with 1. `fiq_o` is the OR of pending, enabled sources typed 1. Such sources never raise `irq_o` and are never returned by a vector read.
- R5: `irq_o` is high exactly when some pending, enabled source typed 0 has a lower index than every source in service.
- R6: A read of VECTOR (word 0x08) while `irq_o` is high returns the handler address of the lowest-index eligible source and marks that source as in service.
- R7: A read of VECTOR while `irq_o` is low returns DEFVEC (word 0x09, read/write) and changes no state.
- R8: Any write to VECTOR ends service of the lowest-index source in service. If nothing is in service, the write has no effect.
- R9: RAW (word 0x00) reads the sources ORed with the soft bits. IRQST (word 0x01) reads the pending, enabled sources typed 0. FIQST (word 0x02) reads the pending, enabled sources typed 1.
- R10: SOFT (word 0x07, read/write) raises the sources whose bits are 1, exactly as the external inputs do.
- R11: The handler address of source i is read and written at word 0x20+i.
- R12: Read data appears on `bus_rdata` after the clock edge of the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level interrupt sources, bit i is source i |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Vectored normal request |
| fiq_o | output | 1 | Fast request |

## Verification
Suppose the in-service set held a wrong bit. `irq_o` would then fail to rise, or stay high, in the very cycle a source changes. The next vector read would also return the wrong handler or the default address. Suppose instead an end-of-service write cleared the wrong bit. A higher-index source still pending would be unmasked too early or too late, and this shows on `irq_o` right after that write edge. The bench therefore samples `irq_o` after every service step of a nested sequence, and compares every vector read against the address expected for that step.

// File: rtl/vic_pkg.sv
package vic_pkg;

    // Word offsets in the control half of the register space
    typedef enum logic [3:0] {
        OFF_RAW    = 4'h0,
        OFF_IRQST  = 4'h1,
        OFF_FIQST  = 4'h2,
        OFF_ENABLE = 4'h3,
        OFF_ENSET  = 4'h4,
        OFF_ENCLR  = 4'h5,
        OFF_TYPE   = 4'h6,
        OFF_SOFT   = 4'h7,
        OFF_VECTOR = 4'h8,
        OFF_DEFVEC = 4'h9
    } reg_off_e;

    // Service command toward the in-service tracker
    typedef struct packed {
        logic take;   // vector read accepted: mark winner in service
        logic done;   // vector write: end highest-priority service
    } svc_cmd_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned addr_width(input int unsigned iw);
        return ((iw > 4) ? iw : 4) + 1;
    endfunction

endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W  = vic_pkg::idx_width(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] in_svc,
    output logic               win_any,
    output logic [IDX_W-1:0]   win_idx
);

    logic [NUM_SRC-1:0] ceil_mask;
    logic [NUM_SRC-1:0] eligible;

    // Only sources strictly above the best in-service source are allowed
    always_comb begin
        ceil_mask = '1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (in_svc[i]) begin
                ceil_mask = (NUM_SRC'(1) << i) - NUM_SRC'(1);
            end
        end
    end

    assign eligible = pend & ceil_mask;
    assign win_any  = |eligible;

    always_comb begin
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_vec_bank.sv
module vic_vec_bank #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = vic_pkg::idx_width(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [DATA_W-1:0] bus_vec,
    output logic [DATA_W-1:0] win_vec
);

    logic [DATA_W-1:0] entry [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
        logic [DATA_W-1:0] addr_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q <= '0;
            end else if (we && (w_idx == IDX_W'(g))) begin
                addr_q <= w_data;
            end
        end
        assign entry[g] = addr_q;
    end

    always_comb begin
        bus_vec = '0;
        win_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_idx == IDX_W'(i)) bus_vec = entry[i];
            if (win_idx == IDX_W'(i)) win_vec = entry[i];
        end
    end

endmodule

// File: rtl/vic_svc_track.sv
module vic_svc_track #(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W  = vic_pkg::idx_width(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  vic_pkg::svc_cmd_t  cmd,
    input  logic [IDX_W-1:0]   take_idx,
    output logic [NUM_SRC-1:0] in_svc
);

    logic [NUM_SRC-1:0] svc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= '0;
        end else if (cmd.take) begin
            svc_q <= svc_q | (NUM_SRC'(1) << take_idx);
        end else if (cmd.done) begin
            // drop the lowest set bit: the highest-priority service
            svc_q <= svc_q & (svc_q - NUM_SRC'(1));
        end
    end

    assign in_svc = svc_q;

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = vic_pkg::idx_width(NUM_SRC),
    localparam int unsigned ADDR_W = vic_pkg::addr_width(IDX_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    import vic_pkg::*;

    logic [NUM_SRC-1:0] en_q, type_q, soft_q;
    logic [DATA_W-1:0]  defvec_q, rdata_q;
    logic [NUM_SRC-1:0] isr_q;
    logic [NUM_SRC-1:0] raw, irq_pend, fiq_pend;
    logic               wr_hit, rd_hit, is_bank, is_ctrl;
    logic [3:0]         off;
    logic               win_any;
    logic [IDX_W-1:0]   win_idx;
    logic [DATA_W-1:0]  bank_rd, win_vec, rd_val;
    svc_cmd_t           svc_cmd;

    // ---------------- decode ----------------
    assign wr_hit  = bus_sel & bus_wr;
    assign rd_hit  = bus_sel & ~bus_wr;
    assign is_bank = bus_addr[ADDR_W-1];
    assign is_ctrl = (bus_addr[ADDR_W-1:4] == '0);
    assign off     = bus_addr[3:0];

    // ---------------- source routing ----------------
    assign raw      = src_i | soft_q;
    assign irq_pend = raw & en_q & ~type_q;
    assign fiq_pend = raw & en_q & type_q;
    assign fiq_o    = |fiq_pend;
    assign irq_o    = win_any;

    // ---------------- control registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            type_q   <= '0;
            soft_q   <= '0;
            defvec_q <= '0;
        end else if (wr_hit && is_ctrl) begin
            case (off)
                4'(OFF_ENSET):  en_q     <= en_q | bus_wdata[NUM_SRC-1:0];
                4'(OFF_ENCLR):  en_q     <= en_q & ~bus_wdata[NUM_SRC-1:0];
                4'(OFF_TYPE):   type_q   <= bus_wdata[NUM_SRC-1:0];
                4'(OFF_SOFT):   soft_q   <= bus_wdata[NUM_SRC-1:0];
                4'(OFF_DEFVEC): defvec_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // ---------------- priority, vectors, service ----------------
    vic_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend    (irq_pend),
        .in_svc  (isr_q),
        .win_any (win_any),
        .win_idx (win_idx)
    );

    vic_vec_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_hit & is_bank),
        .w_idx   (bus_addr[IDX_W-1:0]),
        .w_data  (bus_wdata),
        .bus_idx (bus_addr[IDX_W-1:0]),
        .win_idx (win_idx),
        .bus_vec (bank_rd),
        .win_vec (win_vec)
    );

    always_comb begin
        svc_cmd.take = rd_hit & is_ctrl & (off == 4'(OFF_VECTOR)) & win_any;
        svc_cmd.done = wr_hit & is_ctrl & (off == 4'(OFF_VECTOR));
    end

    vic_svc_track #(.NUM_SRC(NUM_SRC)) u_svc (
        .clk      (clk),
        .rst      (rst),
        .cmd      (svc_cmd),
        .take_idx (win_idx),
        .in_svc   (isr_q)
    );

    // ---------------- read path ----------------
    always_comb begin
        rd_val = '0;
        if (is_bank) begin
            rd_val = bank_rd;
        end else if (is_ctrl) begin
            case (off)
                4'(OFF_RAW):    rd_val = DATA_W'(raw);
                4'(OFF_IRQST):  rd_val = DATA_W'(irq_pend);
                4'(OFF_FIQST):  rd_val = DATA_W'(fiq_pend);
                4'(OFF_ENABLE): rd_val = DATA_W'(en_q);
                4'(OFF_TYPE):   rd_val = DATA_W'(type_q);
                4'(OFF_SOFT):   rd_val = DATA_W'(soft_q);
                4'(OFF_VECTOR): rd_val = win_any ? win_vec : defvec_q;
                4'(OFF_DEFVEC): rd_val = defvec_q;
                default:        rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_hit) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] isr_q,
    input logic [NUM_SRC-1:0] en_q
);
    import vic_pkg::*;

    logic vec_rd, vec_wr, clr_all;
    assign vec_rd  = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(OFF_VECTOR));
    assign vec_wr  = bus_sel &  bus_wr & (bus_addr == ADDR_W'(OFF_VECTOR));
    assign clr_all = bus_sel &  bus_wr & (bus_addr == ADDR_W'(OFF_ENCLR))
                     & (bus_wdata[NUM_SRC-1:0] == '1);

    AST_CLEAR_ALL_SILENCES: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (en_q == '0) && !irq_o && !fiq_o);                          // R3

    AST_TAKE_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && irq_o) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1)); // R6

    AST_IDLE_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && !irq_o) |=> $stable(isr_q));                                 // R7

    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (vec_wr && (isr_q != '0)) |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R8

    AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (rst)
        (vec_wr && (isr_q == '0)) |=> (isr_q == '0));                           // R8

    AST_SVC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(vec_rd || vec_wr) |=> $stable(isr_q));                                // R6

endmodule

bind vic_ctrl vic_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .isr_q     (isr_q),
    .en_q      (en_q)
);

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
    localparam int CLK_P = 10;

    localparam logic [5:0] A_RAW = 6'h00, A_IRQST = 6'h01, A_FIQST = 6'h02,
                           A_EN = 6'h03, A_ENSET = 6'h04, A_ENCLR = 6'h05,
                           A_TYPE = 6'h06, A_SOFT = 6'h07, A_VEC = 6'h08,
                           A_DEFV = 6'h09, A_BANK = 6'h20;
    localparam logic [31:0] DEFV = 32'hDEAD_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; string tag; } sb_item_t;
    sb_item_t sbq[$];
    logic rd_track = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vic_ctrl dut (
        .clk(clk), .rst(rst), .src_i(src), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [31:0] vec_of(input int i);
        return 32'h1000_0000 | (32'(i) << 4);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: one registered read result per tracked read
    always_ff @(posedge clk) rd_track <= sel & ~wr;

    always @(negedge clk) begin
        if (rd_track) begin
            if (sbq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 actual unexpected-read expected none");
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(it.tag, rdata, it.exp);
            end
        end
    end

    // Driver tasks: called at a negedge, return at the next negedge
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        #1;
    endtask

    task automatic pins(input string tag, input logic ei, input logic ef);
        check({tag, " irq_o"}, 32'(irq), 32'(ei));
        check({tag, " fiq_o"}, 32'(fiq), 32'(ef));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        pins("R1 reset", 1'b0, 1'b0);
        bus_read(A_EN,   32'h0, "R1 enable reset");
        bus_read(A_TYPE, 32'h0, "R1 type reset");
        bus_read(A_VEC,  32'h0, "R1 vector reset");
        bus_read(A_BANK + 6'd9, 32'h0, "R1 bank reset");

        // R11 per-source vectors
        for (int i = 0; i < 32; i++) bus_write(A_BANK + 6'(i), vec_of(i));
        bus_read(A_BANK + 6'd5,  vec_of(5),  "R11 bank 5");
        bus_read(A_BANK + 6'd31, vec_of(31), "R11 bank 31");

        // R7 default vector with nothing active
        bus_write(A_DEFV, DEFV);
        bus_read(A_VEC, DEFV, "R7 idle read");

        // R5 / R9 disabled sources stay quiet
        src = 32'h28; #1;
        pins("R5 disabled", 1'b0, 1'b0);
        bus_read(A_RAW, 32'h28, "R9 raw");

        // R2 write-one-to-set
        bus_write(A_ENSET, 32'h20);
        bus_read(A_EN, 32'h20, "R2 set bit5");
        bus_write(A_ENSET, 32'h08);
        bus_read(A_EN, 32'h28, "R2 zeros keep bit5");
        pins("R5 enabled", 1'b1, 1'b0);
        bus_read(A_IRQST, 32'h28, "R9 irq status");

        // R6 take source 3, source 5 masked behind it
        bus_read(A_VEC, vec_of(3), "R6 take 3");
        pins("R5 masked by svc 3", 1'b0, 1'b0);
        bus_read(A_VEC, DEFV, "R7 read while masked");
        pins("R7 state unchanged", 1'b0, 1'b0);

        // R5 / R6 nesting with source 0
        bus_write(A_ENSET, 32'h01);
        src = 32'h29; #1;
        pins("R5 preempt by 0", 1'b1, 1'b0);
        bus_read(A_VEC, vec_of(0), "R6 take 0 nested");
        pins("R5 svc 0 and 3", 1'b0, 1'b0);
        src = 32'h28; #1;
        bus_write(A_VEC, 32'h0);
        pins("R8 end 0, 3 still masks", 1'b0, 1'b0);
        bus_write(A_VEC, 32'h1234);
        pins("R8 end 3", 1'b1, 1'b0);
        bus_read(A_VEC, vec_of(3), "R8 retake 3");
        bus_write(A_VEC, 32'h0);
        src = 32'h20; #1;
        bus_read(A_VEC, vec_of(5), "R6 take 5");
        bus_write(A_VEC, 32'h0);
        bus_write(A_VEC, 32'h0);
        pins("R8 empty end no effect", 1'b1, 1'b0);

        // R4 fast routing
        bus_write(A_TYPE, 32'h20);
        pins("R4 source5 fast", 1'b0, 1'b1);
        bus_read(A_FIQST, 32'h20, "R9 fiq status");
        bus_read(A_IRQST, 32'h00, "R4 irq status empty");
        bus_read(A_VEC, DEFV, "R4 fast not vectored");

        // R3 write-one-to-clear
        bus_write(A_ENCLR, 32'h08);
        bus_read(A_EN, 32'h21, "R3 zeros keep bit5");
        pins("R3 fast still on", 1'b0, 1'b1);
        bus_write(A_ENCLR, 32'hFFFF_FFFF);
        bus_read(A_EN, 32'h0, "R3 clear all");
        pins("R3 all off", 1'b0, 1'b0);

        // R10 soft sources
        src = '0; #1;
        bus_write(A_SOFT, 32'h80);
        bus_read(A_RAW, 32'h80, "R10 soft raw");
        bus_write(A_ENSET, 32'h80);
        pins("R10 soft raises irq", 1'b1, 1'b0);
        bus_read(A_VEC, vec_of(7), "R10 soft vector");
        bus_write(A_VEC, 32'h0);
        bus_write(A_SOFT, 32'h0);
        pins("R10 soft removed", 1'b0, 1'b0);

        // R6 boundary source 31
        bus_write(A_ENSET, 32'h8000_0000);
        src = 32'h8000_0000; #1;
        pins("R6 src31 pending", 1'b1, 1'b0);
        bus_read(A_VEC, vec_of(31), "R6 take 31");
        pins("R6 src31 in service", 1'b0, 1'b0);

        // R12 read data holds between reads
        @(negedge clk); #1;
        check("R12 hold", rdata, vec_of(31));

        repeat (2) @(negedge clk);
        if (sbq.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12 actual %0d pending expected 0", sbq.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule